// File: doc/BRIEF.md
# Playback Channel Sample Unpacker

This block is a single playback channel for a serial audio-codec link controller. A bus master writes packed 32-bit words into a small channel FIFO. Each word holds two 16-bit samples. The block hands out one sample per audio frame to the serial frame builder, formatted as a 20-bit slot value. The low half of a word is handed out first and the high half on the next frame.

Refill uses a request/acknowledge handshake. While the channel is enabled and the FIFO has room for a full burst, the block raises a request. The master answers by writing a burst of words to the channel and then pulses the acknowledge for one clock. The block drops its request on that pulse and evaluates it again one cycle later.

The frame builder pulses a consume strobe once per frame, and only for frames in which this slot is valid. If the FIFO is empty at that moment, the block delivers a zero slot and sets a sticky underrun flag. Deasserting the channel enable empties the FIFO and returns to the low half.

Top module: `audio_play_unpacker`

## Requirements
- R1: Each stored 32-bit word yields two slots in order. Bits [15:0] go out on the first consume strobe and bits [31:16] on the next one. The word is then removed from the FIFO.
- R2: A slot value carries the 16-bit sample in bits [19:4], and bits [3:0] are zero. `slotData` always shows the slot that the next consume strobe will take.
- R3: The FIFO holds 8 words. A write that arrives while all 8 are occupied is dropped, and the words already stored are unaffected.
- R4: While enabled, `dmaReq` rises at the clock edge after the FIFO has at least 4 free words. Once raised, it stays high until an acknowledge, even if the free space falls below 4 during the burst.
- R5: At the clock edge where `dmaAck` is high, `dmaReq` goes low. At the following edge it rises again only if at least 4 words are free at that point.
- R6: A consume strobe on an empty FIFO shows a zero slot and sets `underrun` at the next edge. `underrun` stays set until `underrunClr` clears it at an edge. If a new underrun and a clear arrive together, the underrun wins.
- R7: While `chanEn` is low, the FIFO is emptied, the half select returns to the low half, and `dmaReq` is low. Writes and consume strobes in that time are ignored.
- R8: A write and a word-completing consume strobe in the same cycle both take effect.
- R9: During reset, the FIFO is empty, `dmaReq` and `underrun` are low, and `slotData` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanEn | input | 1 | Channel enable; low flushes the channel |
| wrEn | input | 1 | Write strobe for one packed word |
| wrData | input | 32 | Packed word: two 16-bit samples |
| slotTake | input | 1 | Frame builder consumes the current slot |
| slotData | output | 20 | Current slot value, left-justified sample |
| dmaReq | output | 1 | Refill request for one burst |
| dmaAck | input | 1 | One-cycle acknowledge after a burst |
| underrun | output | 1 | Sticky flag: slot consumed while empty |
| underrunClr | input | 1 | Clears the underrun flag |

## Verification
A wrong word count or half select inside the block would show up at `slotData` on the very next consume strobe. The result is a swapped, repeated or skipped sample, or a zero slot appearing too early or too late. The bench compares each consumed slot against a reference queue built from the written words.

A count error also shifts the request timing. The bench checks `dmaReq` one cycle after each write burst, acknowledge and drain that moves the free space across the burst size. A stuck underrun or a missed flush becomes visible within one cycle of the triggering strobe or disable.

// File: rtl/aup_pkg.sv
package aup_pkg;
  // strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic push;      // store wrData at the tail
    logic pop;       // retire the head word
    logic flush;     // empty the pointers
    logic selHigh;   // present the upper half of the head word
    logic holdZero;  // no data: present a zero slot
  } aup_strobe_t;
endpackage

// File: rtl/aup_control.sv
module aup_control
  import aup_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int BURST = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chanEn,
  input  logic        wrEn,
  input  logic        slotTake,
  input  logic        dmaAck,
  input  logic        underrunClr,
  output aup_strobe_t strb,
  output logic        dmaReq,
  output logic        underrun
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] wordCnt;
  logic [CNT_W-1:0] freeCnt;
  logic             half;
  logic             isEmpty;
  logic             isFull;
  logic             take;

  assign isEmpty = (wordCnt == '0);
  assign isFull  = (wordCnt == CNT_W'(DEPTH));
  assign freeCnt = CNT_W'(DEPTH) - wordCnt;
  assign take    = chanEn & slotTake & ~isEmpty;

  always_comb begin
    strb.push     = chanEn & wrEn & ~isFull;
    strb.pop      = take & half;
    strb.flush    = ~chanEn;
    strb.selHigh  = half;
    strb.holdZero = isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
      half    <= 1'b0;
    end else if (strb.flush) begin
      wordCnt <= '0;
      half    <= 1'b0;
    end else begin
      wordCnt <= wordCnt + CNT_W'(strb.push) - CNT_W'(strb.pop);
      half    <= half ^ take;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                  dmaReq <= 1'b0;
    else if (!chanEn || dmaAck) dmaReq <= 1'b0;
    else if (freeCnt >= CNT_W'(BURST)) dmaReq <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              underrun <= 1'b0;
    else if (chanEn && slotTake && isEmpty) underrun <= 1'b1;
    else if (underrunClr)                   underrun <= 1'b0;
  end

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= CNT_W'(DEPTH));
  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && !dmaAck && chanEn) |=> dmaReq);
  a_r5_ack_drops: assert property (@(posedge clk) disable iff (!rstN)
    dmaAck |=> !dmaReq);
  a_r6_underrun_set: assert property (@(posedge clk) disable iff (!rstN)
    (chanEn && slotTake && isEmpty) |=> underrun);
  a_r7_flush_empty: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn |=> (isEmpty && !half && !dmaReq));
endmodule

// File: rtl/aup_datapath.sv
module aup_datapath
  import aup_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 20,
  parameter int DEPTH    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aup_strobe_t       strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [SLOT_W-1:0] slotData
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int PAD_W = SLOT_W - SAMPLE_W;

  logic [DATA_W-1:0]   mem [DEPTH];
  logic [PTR_W-1:0]    wrPtr;
  logic [PTR_W-1:0]    rdPtr;
  logic [DATA_W-1:0]   headWord;
  logic [SAMPLE_W-1:0] sample;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  assign headWord = mem[rdPtr];
  assign sample   = strb.selHigh ? headWord[2*SAMPLE_W-1:SAMPLE_W]
                                 : headWord[SAMPLE_W-1:0];

  always_comb begin
    if (strb.holdZero) slotData = '0;
    else               slotData = {sample, {PAD_W{1'b0}}};
  end

  // R2: the low nibble is always empty
  a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rstN)
    slotData[PAD_W-1:0] == '0);
endmodule

// File: rtl/audio_play_unpacker.sv
module audio_play_unpacker #(
  parameter int DATA_W   = 32,
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 20,
  parameter int DEPTH    = 8,
  parameter int BURST    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              slotTake,
  output logic [SLOT_W-1:0] slotData,
  output logic              dmaReq,
  input  logic              dmaAck,
  output logic              underrun,
  input  logic              underrunClr
);
  aup_pkg::aup_strobe_t strb;

  aup_control #(.DEPTH(DEPTH), .BURST(BURST)) u_ctrl (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrEn(wrEn),
    .slotTake(slotTake), .dmaAck(dmaAck), .underrunClr(underrunClr),
    .strb(strb), .dmaReq(dmaReq), .underrun(underrun)
  );

  aup_datapath #(.DATA_W(DATA_W), .SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W),
                 .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .slotData(slotData)
  );

  // R9: a held reset leaves nothing to play
  a_r9_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (slotData == '0 && !dmaReq && !underrun));
endmodule

// File: tb/tb_audio_play_unpacker.sv
`timescale 1ns/1ps
module tb_audio_play_unpacker;
  logic        clk = 1'b0;
  logic        rstN, chanEn, wrEn, slotTake, dmaAck, underrunClr;
  logic [31:0] wrData;
  logic [19:0] slotData;
  logic        dmaReq, underrun;

  int applied = 0;
  int failed  = 0;
  logic [19:0] expQ[$];

  always #2 clk = ~clk;

  audio_play_unpacker dut (
    .clk(clk), .rstN(rstN), .chanEn(chanEn), .wrEn(wrEn), .wrData(wrData),
    .slotTake(slotTake), .slotData(slotData), .dmaReq(dmaReq),
    .dmaAck(dmaAck), .underrun(underrun), .underrunClr(underrunClr)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic nextCyc();
    @(posedge clk); #1;
  endtask

  // driver side of the scoreboard: a write adds two expected slots
  function automatic void modelWrite(input logic [31:0] w);
    if (chanEn && ((expQ.size() + 1) / 2) < 8) begin
      expQ.push_back({w[15:0], 4'h0});
      expQ.push_back({w[31:16], 4'h0});
    end
  endfunction

  task automatic writeWord(input logic [31:0] w);
    modelWrite(w);
    wrEn = 1'b1; wrData = w;
    nextCyc();
    wrEn = 1'b0;
  endtask

  task automatic takeSlot();
    slotTake = 1'b1;
    nextCyc();
    slotTake = 1'b0;
  endtask

  task automatic writeAndTake(input logic [31:0] w);
    modelWrite(w);
    wrEn = 1'b1; wrData = w; slotTake = 1'b1;
    nextCyc();
    wrEn = 1'b0; slotTake = 1'b0;
  endtask

  task automatic ackPulse();
    dmaAck = 1'b1;
    nextCyc();
    dmaAck = 1'b0;
  endtask

  // monitor side: compare each consumed slot before the consuming edge
  always @(negedge clk) begin
    if (rstN && slotTake && chanEn) begin
      if (expQ.size() == 0)
        check(slotData == 20'h0, "R6 empty slot", {12'h0, slotData}, 32'h0);
      else begin
        logic [19:0] e;
        e = expQ.pop_front();
        check(slotData == e, "R1 R2 slot order/format", {12'h0, slotData}, {12'h0, e});
      end
    end
  end

  function automatic logic [31:0] pat(input int i);
    return 32'hA531_0000 + i * 32'h0123_1357;
  endfunction

  initial begin
    #200000;
    failed++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end

  initial begin
    rstN = 0; chanEn = 1; wrEn = 0; slotTake = 0; dmaAck = 0;
    underrunClr = 0; wrData = '0;
    repeat (3) nextCyc();
    @(negedge clk);
    check(!dmaReq, "R9 req in reset", dmaReq, 0);
    check(!underrun, "R9 underrun in reset", underrun, 0);
    check(slotData == 0, "R9 slot in reset", slotData, 0);
    nextCyc(); rstN = 1;
    nextCyc();
    @(negedge clk);
    check(dmaReq, "R4 req after reset", dmaReq, 1);

    // burst of four, request must hold until ack
    for (int i = 0; i < 4; i++) writeWord(pat(i));
    @(negedge clk);
    check(dmaReq, "R4 req held during burst", dmaReq, 1);
    ackPulse();
    @(negedge clk);
    check(!dmaReq, "R5 req dropped on ack", dmaReq, 0);
    nextCyc();
    @(negedge clk);
    check(dmaReq, "R5 req re-evaluated high", dmaReq, 1);

    writeWord(pat(4));        // 5 words, 3 free
    ackPulse();
    @(negedge clk);
    check(!dmaReq, "R5 req dropped", dmaReq, 0);
    nextCyc();
    @(negedge clk);
    check(!dmaReq, "R5 req stays low with 3 free", dmaReq, 0);

    @(negedge clk);
    check(slotData == {pat(0)[15:0], 4'h0}, "R2 head slot", slotData, {pat(0)[15:0], 4'h0});
    nextCyc();
    takeSlot(); takeSlot();   // retires word 0, 4 free
    nextCyc();
    @(negedge clk);
    check(dmaReq, "R4 req after drain", dmaReq, 1);

    // overfill: 4 accepted, 2 dropped
    for (int i = 5; i < 11; i++) writeWord(pat(i));
    check(expQ.size() == 16, "R3 model fill", expQ.size(), 16);
    for (int i = 0; i < 16; i++) takeSlot();

    // underrun
    takeSlot();
    @(negedge clk);
    check(underrun, "R6 underrun set", underrun, 1);
    nextCyc();
    @(negedge clk);
    check(underrun, "R6 underrun sticky", underrun, 1);
    underrunClr = 1; nextCyc(); underrunClr = 0;
    @(negedge clk);
    check(!underrun, "R6 underrun cleared", underrun, 0);

    // simultaneous write and word-completing take
    writeWord(pat(20));
    takeSlot();
    writeAndTake(pat(21));
    for (int i = 0; i < 2; i++) takeSlot();
    @(negedge clk);
    check(slotData == 0, "R8 drained after both", slotData, 0);
    check(expQ.size() == 0, "R8 model drained", expQ.size(), 0);

    // flush on disable
    writeWord(pat(30)); writeWord(pat(31));
    takeSlot();
    chanEn = 0; expQ.delete();
    nextCyc();
    writeWord(pat(32)); takeSlot();
    @(negedge clk);
    check(!dmaReq, "R7 req low while disabled", dmaReq, 0);
    check(slotData == 0, "R7 flushed", slotData, 0);
    chanEn = 1;
    nextCyc();
    @(negedge clk);
    check(slotData == 0, "R7 writes ignored while disabled", slotData, 0);
    check(!underrun, "R7 take ignored while disabled", underrun, 0);
    writeWord(pat(33));
    takeSlot(); takeSlot();
    nextCyc();

    $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
    $finish;
  end
endmodule